// File: doc/BRIEF.md
# Front-Panel Pushbutton Press Classifier

This block watches one front-panel pushbutton and sorts each press by how long it is held. The raw switch line is active low and asynchronous to the clock. It passes through a two-flop synchronizer and then a debounce filter. A single hold timer measures how long the filtered press lasts, and a small state machine turns that duration into one of three outcomes:

- A short press, released in under one second, raises a one-cycle access-disable interrupt.
- A press released between one and three seconds does nothing.
- A press still held at the three-second mark raises a pre-reset notice to the host. Exactly one second later a hard reset pulse follows.

The pre-reset notice and the short-press interrupt leave on separate lines. Once the pre-reset notice has gone out, the hard reset follows whether or not the button is still held. After the reset pulse the block waits for the button to be let go before it accepts a new press. Every duration is derived from a clock-frequency parameter and millisecond parameters.

State machine:

- `BP_IDLE` waits for a filtered press and moves to `BP_HELD`.
- `BP_HELD` times the press. On release it goes back to `BP_IDLE`, firing the interrupt only if the hold was under one second. At the three-second mark it moves to `BP_ARMED` and fires the pre-reset notice.
- `BP_ARMED` waits one second and moves to `BP_RESET`.
- `BP_RESET` drives the hard reset for the pulse length and then moves to `BP_DRAIN`.
- `BP_DRAIN` waits for a filtered release and returns to `BP_IDLE`.

Top module: `btn_press_classifier`

## Requirements
- R1: The raw line is sampled through a two-flop synchronizer whose flops reset to the released level (high). A change on the line therefore takes two clocks to reach the debounce filter.
- R2: The filtered level changes only after the synchronized line has differed from it for DEBOUNCE_MS milliseconds of consecutive clocks. A low pulse or bounce shorter than that window produces no output.
- R3: A filtered press released before SHORT_LIMIT_MS has elapsed raises `short_irq_o` for exactly one clock, in the clock after the release is seen.
- R4: A filtered press released after SHORT_LIMIT_MS but before PRE_RESET_MS produces no pulse on any output.
- R5: A press still held when PRE_RESET_MS is reached raises `pre_reset_o` for exactly one clock. If the release is seen in the same clock as the mark, the release wins and no pre-reset is issued.
- R6: `hard_reset_o` rises exactly RESET_DELAY_MS milliseconds of clocks after the clock in which `pre_reset_o` was high. It stays high for RESET_PULSE_CYC clocks.
- R7: Once `pre_reset_o` has fired, the hard reset follows on schedule even if the button is released during the wait.
- R8: After the hard reset pulse, a press that is still held produces nothing more. Its release raises no `short_irq_o`, and the next press is classified normally.
- R9: While reset is applied, and in the first clock after it, all three outputs are low.
- R10: At most one of the three outputs is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_raw_n_i | input | 1 | Raw pushbutton line, asynchronous, low while pressed |
| short_irq_o | output | 1 | One-cycle access-disable interrupt for a short press |
| pre_reset_o | output | 1 | One-cycle pre-reset notice to the host |
| hard_reset_o | output | 1 | Hard reset pulse, RESET_PULSE_CYC clocks long |

## Verification
Two events can land in the same clock: the filtered release and the three-second pre-reset mark. In that clock the state machine has to choose between a silent return to idle and issuing the pre-reset notice. The bench provokes this with presses whose raw length sits one or two clocks on either side of the mark. A behavioural reference model, compared on every clock, decides which outcome is right. A second collision is a release while the block is armed or resetting, which must not disturb the hard reset schedule and must not be read as a short press.

// File: rtl/btn_pkg.sv
package btn_pkg;

    typedef enum logic [2:0] {
        BP_IDLE,
        BP_HELD,
        BP_ARMED,
        BP_RESET,
        BP_DRAIN
    } btn_state_e;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[i] <= RESET_VAL;
                    else       chain_q[i] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[i] <= RESET_VAL;
                    else       chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int DB_CYC = 80
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic level_o
);

    localparam int DW = $clog2(DB_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(DB_CYC - 1);

    logic [DW-1:0] run_q;
    logic          stable_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q    <= '0;
            stable_q <= 1'b0;
        end else if (level_i != stable_q) begin
            if (run_q == LAST) begin
                stable_q <= level_i;
                run_q    <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level_o = stable_q;

endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
    parameter int TW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    output logic [TW-1:0] elapsed_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)  cnt_q <= '0;
        else if (&cnt_q)     cnt_q <= cnt_q;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign elapsed_o = cnt_q;

endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
    import btn_pkg::*;
#(
    parameter int TW        = 8,
    parameter int SHORT_CYC = 40,
    parameter int PRE_CYC   = 120,
    parameter int DELAY_CYC = 40,
    parameter int PULSE_CYC = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          pressed_i,
    input  logic [TW-1:0] elapsed_i,
    output logic          timer_clr_o,
    output logic          short_o,
    output logic          pre_o,
    output logic          hard_o
);

    localparam logic [TW-1:0] SHORT_L = TW'(SHORT_CYC);
    localparam logic [TW-1:0] PRE_L   = TW'(PRE_CYC - 1);
    localparam logic [TW-1:0] DELAY_L = TW'(DELAY_CYC - 1);
    localparam logic [TW-1:0] PULSE_L = TW'(PULSE_CYC - 1);

    btn_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= BP_IDLE;
        else       state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_IDLE:  if (pressed_i) state_d = BP_HELD;
            BP_HELD: begin
                if (!pressed_i)              state_d = BP_IDLE;
                else if (elapsed_i == PRE_L) state_d = BP_ARMED;
            end
            BP_ARMED: if (elapsed_i == DELAY_L) state_d = BP_RESET;
            BP_RESET: if (elapsed_i == PULSE_L) state_d = BP_DRAIN;
            BP_DRAIN: if (!pressed_i) state_d = BP_IDLE;
            default:  state_d = BP_IDLE;
        endcase
    end

    assign timer_clr_o = (state_q != state_d);

    // registered outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            short_o <= 1'b0;
            pre_o   <= 1'b0;
            hard_o  <= 1'b0;
        end else begin
            short_o <= (state_q == BP_HELD) && !pressed_i && (elapsed_i < SHORT_L);
            pre_o   <= (state_q == BP_HELD) && (state_d == BP_ARMED);
            hard_o  <= (state_d == BP_RESET);
        end
    end

endmodule

// File: rtl/btn_press_classifier.sv
module btn_press_classifier #(
    parameter int CLK_FREQ_HZ     = 125_000_000,
    parameter int DEBOUNCE_MS     = 20,
    parameter int SHORT_LIMIT_MS  = 1000,
    parameter int PRE_RESET_MS    = 3000,
    parameter int RESET_DELAY_MS  = 1000,
    parameter int RESET_PULSE_CYC = 16,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_raw_n_i,
    output logic short_irq_o,
    output logic pre_reset_o,
    output logic hard_reset_o
);

    localparam int CYC_PER_MS    = CLK_FREQ_HZ / 1000;
    localparam int DB_CYC        = DEBOUNCE_MS * CYC_PER_MS;
    localparam int SHORT_CYC     = SHORT_LIMIT_MS * CYC_PER_MS;
    localparam int PRE_CYC       = PRE_RESET_MS * CYC_PER_MS;
    localparam int RST_DELAY_CYC = RESET_DELAY_MS * CYC_PER_MS;
    localparam int MAX_A         = (PRE_CYC > RST_DELAY_CYC) ? PRE_CYC : RST_DELAY_CYC;
    localparam int MAX_CYC       = (MAX_A > RESET_PULSE_CYC) ? MAX_A : RESET_PULSE_CYC;
    localparam int TW            = $clog2(MAX_CYC + 1);

    logic          sync_n;
    logic          filt_pressed;
    logic          timer_clr;
    logic [TW-1:0] elapsed;

    btn_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (btn_raw_n_i),
        .q_o   (sync_n)
    );

    btn_debounce #(.DB_CYC(DB_CYC)) u_debounce (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (~sync_n),
        .level_o (filt_pressed)
    );

    btn_hold_timer #(.TW(TW)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (timer_clr),
        .elapsed_o (elapsed)
    );

    btn_press_fsm #(
        .TW        (TW),
        .SHORT_CYC (SHORT_CYC),
        .PRE_CYC   (PRE_CYC),
        .DELAY_CYC (RST_DELAY_CYC),
        .PULSE_CYC (RESET_PULSE_CYC)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pressed_i   (filt_pressed),
        .elapsed_i   (elapsed),
        .timer_clr_o (timer_clr),
        .short_o     (short_irq_o),
        .pre_o       (pre_reset_o),
        .hard_o      (hard_reset_o)
    );

endmodule

// File: rtl/btn_press_checker.sv
module btn_press_checker #(
    parameter int DELAY_CYC = 4000,
    parameter int PULSE_CYC = 16
) (
    input logic clk_i,
    input logic rst_i,
    input logic short_irq_o,
    input logic pre_reset_o,
    input logic hard_reset_o
);

    int   since_pre_q;
    logic armed_q;
    int   hard_len_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_pre_q <= 0;
            armed_q     <= 1'b0;
            hard_len_q  <= 0;
        end else begin
            if (pre_reset_o) begin
                since_pre_q <= 1;
                armed_q     <= 1'b1;
            end else if (armed_q) begin
                since_pre_q <= since_pre_q + 1;
                if (!hard_reset_o && since_pre_q > DELAY_CYC) armed_q <= 1'b0;
            end
            hard_len_q <= hard_reset_o ? hard_len_q + 1 : 0;
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (!short_irq_o && !pre_reset_o && !hard_reset_o));

    // R3
    short_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        short_irq_o |=> !short_irq_o);

    // R5
    pre_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_reset_o |=> !pre_reset_o);

    // R6
    reset_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hard_reset_o) |-> (armed_q && since_pre_q == DELAY_CYC));

    // R6
    reset_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hard_reset_o) |-> (hard_len_q == PULSE_CYC));

    // R10
    exclusive_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({short_irq_o, pre_reset_o, hard_reset_o}));

endmodule

bind btn_press_classifier btn_press_checker #(
    .DELAY_CYC (RST_DELAY_CYC),
    .PULSE_CYC (RESET_PULSE_CYC)
) u_btn_press_checker (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .short_irq_o  (short_irq_o),
    .pre_reset_o  (pre_reset_o),
    .hard_reset_o (hard_reset_o)
);

// File: tb/btn_press_classifier_bench.sv
`timescale 1ns/1ps
module btn_press_classifier_bench;

    localparam int CLK_HZ   = 4000;   // 4 clocks per millisecond
    localparam int CPM      = CLK_HZ / 1000;
    localparam int DB       = 20 * CPM;
    localparam int SHORTC   = 1000 * CPM;
    localparam int PREC     = 3000 * CPM;
    localparam int DELAYC   = 1000 * CPM;
    localparam int PULSEC   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw_n = 1'b1;
    logic short_irq, pre_rst, hard_rst;

    always #4 clk = ~clk;   // 125 MHz

    btn_press_classifier #(
        .CLK_FREQ_HZ     (CLK_HZ),
        .DEBOUNCE_MS     (20),
        .SHORT_LIMIT_MS  (1000),
        .PRE_RESET_MS    (3000),
        .RESET_DELAY_MS  (1000),
        .RESET_PULSE_CYC (PULSEC),
        .SYNC_STAGES     (2)
    ) u_btn_press_classifier (
        .clk_i        (clk),
        .rst_i        (rst),
        .btn_raw_n_i  (raw_n),
        .short_irq_o  (short_irq),
        .pre_reset_o  (pre_rst),
        .hard_reset_o (hard_rst)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // ---------------- behavioural reference model ----------------
    bit pipe[$];            // synchronizer delay line, pressed-form
    bit m_filt;
    int m_run;
    int m_phase;            // 0 idle, 1 timing, 2 armed, 3 resetting, 4 waiting release
    int m_t;
    bit e_short, e_pre, e_hard;

    always @(posedge clk) begin
        if (rst) begin
            pipe = '{0, 0};
            m_filt = 0; m_run = 0; m_phase = 0; m_t = 0;
            e_short = 0; e_pre = 0; e_hard = 0;
        end else begin
            int  np;
            bit  seen;
            np = m_phase;
            e_short = 0; e_pre = 0;
            case (m_phase)
                0: if (m_filt) np = 1;
                1: begin
                    if (!m_filt) begin
                        if (m_t < SHORTC) e_short = 1;
                        np = 0;
                    end else if (m_t == PREC - 1) begin
                        np = 2; e_pre = 1;
                    end
                end
                2: if (m_t == DELAYC - 1) np = 3;
                3: if (m_t == PULSEC - 1) np = 4;
                default: if (!m_filt) np = 0;
            endcase
            e_hard = (np == 3);
            m_t = (np != m_phase) ? 0 : m_t + 1;
            m_phase = np;
            // debounce on the level leaving the synchronizer (R2)
            seen = pipe[1];
            if (seen != m_filt) begin
                m_run++;
                if (m_run == DB) begin m_filt = seen; m_run = 0; end
            end else m_run = 0;
            // two-stage synchronizer (R1)
            pipe.pop_back();
            pipe.push_front(~raw_n);
        end
    end

    // ---------------- per-clock comparison ----------------
    int n_short = 0, n_pre = 0, n_hard = 0;
    bit last_hard = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            // R1 timing is implied: the model delays the line by two clocks
            if (short_irq !== e_short) begin
                fails++;
                $display("FAIL R3 short_irq_o actual %0b expected %0b at %0t", short_irq, e_short, $time);
            end
            if (pre_rst !== e_pre) begin
                fails++;
                $display("FAIL R5 pre_reset_o actual %0b expected %0b at %0t", pre_rst, e_pre, $time);
            end
            if (hard_rst !== e_hard) begin
                fails++;
                $display("FAIL R6 hard_reset_o actual %0b expected %0b at %0t", hard_rst, e_hard, $time);
            end
            if (short_irq) n_short++;
            if (pre_rst)   n_pre++;
            if (hard_rst && !last_hard) n_hard++;
            last_hard = hard_rst;
        end
    end

    task automatic expect_counts(string tag, int es, int ep, int eh);
        checks++;
        if (n_short != es || n_pre != ep || n_hard != eh) begin
            fails++;
            $display("FAIL %s pulses short/pre/hard actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, n_short, n_pre, n_hard, es, ep, eh);
        end
        n_short = 0; n_pre = 0; n_hard = 0;
    endtask

    task automatic hold_low(int n);
        @(negedge clk) raw_n = 1'b0;
        repeat (n) @(negedge clk);
        raw_n = 1'b1;
    endtask

    task automatic rest(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9: outputs low during reset
        checks++;
        if (short_irq || pre_rst || hard_rst) begin
            fails++;
            $display("FAIL R9 outputs during reset actual %0b%0b%0b expected 000", short_irq, pre_rst, hard_rst);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (short_irq || pre_rst || hard_rst) begin
            fails++;
            $display("FAIL R9 outputs after reset actual %0b%0b%0b expected 000", short_irq, pre_rst, hard_rst);
        end
        rest(20);

        // R2: lone glitch shorter than the window
        hold_low(DB / 2);
        rest(300);
        expect_counts("R2 glitch", 0, 0, 0);

        // R2: bouncing contact then a steady short press
        for (int i = 0; i < 4; i++) begin
            hold_low(10);
            rest(10);
        end
        hold_low(400);
        rest(300);
        expect_counts("R2 bounce", 1, 0, 0);

        // R3: short press, near the one-second boundary
        hold_low(500);
        rest(300);
        expect_counts("R3 short", 1, 0, 0);
        hold_low(SHORTC - 100);
        rest(300);
        expect_counts("R3 boundary", 1, 0, 0);

        // R4: mid-length presses
        hold_low(SHORTC + 200);
        rest(300);
        expect_counts("R4 just over", 0, 0, 0);
        hold_low(6000);
        rest(300);
        expect_counts("R4 mid", 0, 0, 0);

        // R5: release just before the three-second mark
        hold_low(PREC - 2);
        rest(300);
        expect_counts("R5 before mark", 0, 0, 0);

        // R5/R6/R7: released soon after the mark, reset still follows
        hold_low(PREC + 1);
        rest(DELAYC + 300);
        expect_counts("R7 released", 0, 1, 1);

        // R8: held through the whole sequence, release gives nothing
        hold_low(PREC + DELAYC + 2000);
        rest(300);
        expect_counts("R8 held", 0, 1, 1);

        // R8: the next press is classified normally
        hold_low(300);
        rest(300);
        expect_counts("R8 next press", 1, 0, 0);

        finish_run();
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired before the sequence completed");
        finish_run();
    end

endmodule